// File: doc/BRIEF.md
# MII Management Master with Register Access

This block lets a host read and write PHY registers over the two-wire management interface, which is a clock line (MDC) and a bidirectional data line (MDIO). The host sees two 32-bit registers. One is a command word. The other holds the 16-bit data value. Writing the command word with its launch bit set starts one Clause 22 management frame. MDC is derived from the system clock, and the divide ratio comes from a code carried in the same command word. MDIO is produced as a data bit and an output enable, for an external tri-state pad.

For a write, the host first loads the data register and then issues the command. For a read, the 16 bits returned by the PHY appear in the data register when the busy bit drops. A command written with the launch bit clear does not start a frame. It produces a single MDC pulse with MDIO released, which lets a PHY that waits for a clock edge finish its reset.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, both register readbacks are zero, MDC is low and the MDIO output enable is low.
- R2: Command word layout. Bits 15:11 are the PHY address. Bits 10:6 are the PHY register number. Bits 5:2 are the clock code. Bit 1 set means write and clear means read. Bit 0 is busy. The readback returns the stored fields, and bit 0 reads 1 from the cycle after an accepted launch until the frame has finished.
- R3: The MDC period is 16, 26, 42 or 62 system clocks for clock codes 0, 1, 2 and 3. Every other code gives 62. High and low halves are equal, and MDC is low whenever busy reads 0.
- R4: A write frame is 64 MDC cycles with MDIO driven throughout. The bits, MSB first, are: 32 ones, 01, opcode 01, PHY address, register number, turnaround 10, then the 16 data-register bits.
- R5: A read frame drives 32 ones, 01, opcode 10, PHY address and register number. It releases MDIO from the turnaround onward (bit positions 46 to 63) and samples MDIO at each rising MDC edge of the 16 data bits. When busy clears, the result is in data-register bits 15:0 with bits 31:16 zero.
- R6: MDIO is driven only while busy reads 1. While driven, its value changes only in the cycle where MDC falls.
- R7: While busy reads 1, command writes and data-register writes are ignored, and both readbacks stay unchanged.
- R8: A command written while idle with bit 0 clear (including all zeros) gives exactly one MDC high pulse. MDIO stays released, busy reads 1 during the pulse, and the data register is unchanged.
- R9: A data-register write while idle stores bits 15:0, and the readback shows them with bits 31:16 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects the command word, 1 the data register |
| reg_wdata_i | input | 32 | Register write data |
| cmd_o | output | 32 | Command word readback |
| data_o | output | 32 | Data register readback |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The hardest case to reach is a host access that arrives in the middle of a frame. The frame must carry on with the captured fields, and the data register must not move. The bench launches a write frame and then, a few cycles later, issues a conflicting command and a new data value. It then checks the readbacks and all 64 captured frame bits against the original values.

A behavioural PHY in the bench handles reads. It watches MDC and drives response bits after each falling edge, so the rising-edge sampling of the master is tested with all-ones, all-zeros and random words. This is done across clock codes picked at random from the full 4-bit range.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int unsigned FRAME_LEN = 64;
  localparam int unsigned POS_W     = $clog2(FRAME_LEN);
  localparam int unsigned TA_POS    = 46;
  localparam int unsigned DATA_POS  = 48;
  localparam int unsigned WORD_W    = 16;

  typedef struct packed {
    logic [4:0] phy;
    logic [4:0] regn;
    logic [3:0] clk_code;
    logic       wr;
  } cmd_t;

  function automatic logic [FRAME_LEN-1:0] build_frame(cmd_t c, logic [WORD_W-1:0] d);
    logic [1:0] op;
    logic [1:0] ta;
    op = c.wr ? 2'b01 : 2'b10;
    ta = c.wr ? 2'b10 : 2'b00;
    return {32'hFFFF_FFFF, 2'b01, op, c.phy, c.regn, ta, c.wr ? d : 16'h0000};
  endfunction
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int unsigned DIV0 = 16,
  parameter int unsigned DIV1 = 26,
  parameter int unsigned DIV2 = 42,
  parameter int unsigned DIV3 = 62
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [3:0] clk_code_i,
  output logic       mdc_o,
  output logic       rise_o,
  output logic       fall_o
);
  localparam int unsigned MAX01   = (DIV0 > DIV1) ? DIV0 : DIV1;
  localparam int unsigned MAX23   = (DIV2 > DIV3) ? DIV2 : DIV3;
  localparam int unsigned MAX_DIV = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int unsigned CNT_W   = $clog2(MAX_DIV / 2 + 1);

  logic [CNT_W-1:0] half_m1, cnt_q;
  logic             mdc_q, tick;

  always_comb begin
    unique case (clk_code_i)
      4'd0:    half_m1 = CNT_W'(DIV0 / 2 - 1);
      4'd1:    half_m1 = CNT_W'(DIV1 / 2 - 1);
      4'd2:    half_m1 = CNT_W'(DIV2 / 2 - 1);
      default: half_m1 = CNT_W'(DIV3 / 2 - 1);
    endcase
  end

  assign tick = run_i && (cnt_q == half_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = tick & ~mdc_q;
  assign fall_o = tick & mdc_q;
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_mgmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              pulse_only_i,
  input  cmd_t              cmd_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              active_o,
  output logic              done_o,
  output logic              rx_valid_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  logic [FRAME_LEN-1:0] shift_q;
  logic [POS_W-1:0]     pos_q;
  logic                 active_q, rd_q, pulse_q;
  logic [WORD_W-1:0]    rx_q;
  logic                 last_bit, in_rx_data, released;

  assign last_bit   = (pos_q == POS_W'(FRAME_LEN - 1));
  assign in_rx_data = (pos_q >= POS_W'(DATA_POS));
  assign released   = rd_q && (pos_q >= POS_W'(TA_POS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q  <= '0;
      pos_q    <= '0;
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      pulse_q  <= 1'b0;
      rx_q     <= '0;
    end else if (start_i) begin
      shift_q  <= build_frame(cmd_i, wdata_i);
      // pulse-only runs just the final bit slot: one low half, one high half
      pos_q    <= pulse_only_i ? POS_W'(FRAME_LEN - 1) : '0;
      active_q <= 1'b1;
      rd_q     <= ~cmd_i.wr & ~pulse_only_i;
      pulse_q  <= pulse_only_i;
      rx_q     <= '0;
    end else if (active_q) begin
      if (rise_i && rd_q && in_rx_data) rx_q <= {rx_q[WORD_W-2:0], mdio_i};
      if (fall_i) begin
        if (last_bit) begin
          active_q <= 1'b0;
        end else begin
          pos_q   <= pos_q + 1'b1;
          shift_q <= {shift_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end

  assign active_o   = active_q;
  assign done_o     = active_q && fall_i && last_bit;
  assign rx_valid_o = done_o && rd_q;
  assign rx_data_o  = rx_q;
  assign mdio_oe_o  = active_q && !pulse_q && !released;
  assign mdio_o     = mdio_oe_o && shift_q[FRAME_LEN-1];
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_mgmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [31:0]       wdata_i,
  input  logic              active_i,
  input  logic              rx_valid_i,
  input  logic [WORD_W-1:0] rx_data_i,
  output logic              start_o,
  output logic              pulse_only_o,
  output cmd_t              new_cmd_o,
  output logic [WORD_W-1:0] data_q_o,
  output logic [31:0]       cmd_o,
  output logic [31:0]       data_o
);
  cmd_t              cmd_q;
  logic [WORD_W-1:0] data_q;
  logic              cmd_acc, data_acc;
  logic              unused_hi;

  assign unused_hi = ^wdata_i[31:16];

  assign new_cmd_o    = '{phy: wdata_i[15:11], regn: wdata_i[10:6],
                          clk_code: wdata_i[5:2], wr: wdata_i[1]};
  assign cmd_acc      = we_i && !sel_i && !active_i;
  assign data_acc     = we_i && sel_i && !active_i;
  assign start_o      = cmd_acc;
  assign pulse_only_o = ~wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (cmd_acc)    cmd_q  <= new_cmd_o;
      if (data_acc)   data_q <= wdata_i[WORD_W-1:0];
      if (rx_valid_i) data_q <= rx_data_i;
    end
  end

  assign data_q_o = data_q;
  assign cmd_o    = {16'h0000, cmd_q.phy, cmd_q.regn, cmd_q.clk_code, cmd_q.wr, active_i};
  assign data_o   = {16'h0000, data_q};
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned DIV0 = 16,
  parameter int unsigned DIV1 = 26,
  parameter int unsigned DIV2 = 42,
  parameter int unsigned DIV3 = 62
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_sel_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] cmd_o,
  output logic [31:0] data_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  cmd_t              new_cmd;
  logic [WORD_W-1:0] data_q, rx_data;
  logic              start, pulse_only, active, done, rx_valid, rise, fall;
  logic [3:0]        run_code;
  logic              unused_done;

  assign run_code    = cmd_o[5:2];
  assign unused_done = done;

  mdio_host_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .active_i(active), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .start_o(start), .pulse_only_o(pulse_only), .new_cmd_o(new_cmd),
    .data_q_o(data_q), .cmd_o(cmd_o), .data_o(data_o)
  );

  mdio_clk_gen #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) u_clk (
    .clk_i, .rst_ni, .run_i(active), .clk_code_i(run_code),
    .mdc_o(mdc_o), .rise_o(rise), .fall_o(fall)
  );

  mdio_frame_seq u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .pulse_only_i(pulse_only), .cmd_i(new_cmd), .wdata_i(data_q),
    .rise_i(rise), .fall_i(fall), .mdio_i(mdio_i),
    .active_o(active), .done_o(done), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
  );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] cmd_o,
  input logic [31:0] data_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);
  // R3
  mdc_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_o[0] |-> !mdc_o);
  // R3
  mdc_high_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |=> mdc_o);
  // R6
  oe_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_o[0] |-> !mdio_oe_o);
  // R6
  mdio_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdio_oe_o && $past(mdio_oe_o) && !$fell(mdc_o)) |-> $stable(mdio_o));
  // R7
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[0] && $past(cmd_o[0])) |-> $stable(cmd_o));
  // R7
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[0] && $past(cmd_o[0])) |-> $stable(data_o));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_o(cmd_o), .data_o(data_o),
  .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
);

// File: tb/mdio_mgmt_master_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, sel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] cmd_o, data_o;
  logic        mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i = 1'b1;

  int checks = 0, fails = 0;
  bit finished = 0;

  // bench PHY / monitor state
  int   cyc = 0, rise_cnt = 0, base = 0, oe_cyc = 0;
  logic mdc_prev = 1'b0;
  logic cap_bit [64];
  logic cap_oe  [64];
  int   rise_cyc[64];
  logic [15:0] resp_q = '0;

  always #2.5 clk = ~clk;

  mdio_mgmt_master u_mdio_mgmt_master (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .cmd_o(cmd_o), .data_o(data_o), .mdc_o(mdc_o), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
  );

  always @(negedge clk) begin
    int idx;
    cyc = cyc + 1;
    if (mdio_oe_o) oe_cyc = oe_cyc + 1;
    idx = rise_cnt - base;
    if (mdc_o && !mdc_prev) begin
      if (idx >= 0 && idx < 64) begin
        cap_bit[idx]  = mdio_o;
        cap_oe[idx]   = mdio_oe_o;
        rise_cyc[idx] = cyc;
      end
      rise_cnt = rise_cnt + 1;
    end
    if (!mdc_o && mdc_prev) begin
      if (idx == 47) mdio_i = 1'b0;
      else if (idx >= 48 && idx <= 63) mdio_i = resp_q[63-idx];
    end
    mdc_prev = mdc_o;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic s, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  function automatic int ratio(input logic [3:0] code);
    case (code)
      4'd0: return 16;
      4'd1: return 26;
      4'd2: return 42;
      default: return 62;
    endcase
  endfunction

  function automatic logic [63:0] exp_frame(input logic [4:0] phy, input logic [4:0] rg,
                                             input logic wr, input logic [15:0] d);
    logic [63:0] f;
    f[63:32] = '1;
    f[31:30] = 2'b01;
    f[29:28] = wr ? 2'b01 : 2'b10;
    f[27:23] = phy;
    f[22:18] = rg;
    f[17:16] = wr ? 2'b10 : 2'b00;
    f[15:0]  = wr ? d : 16'h0;
    return f;
  endfunction

  function automatic logic [31:0] cmd_word(input logic [4:0] phy, input logic [4:0] rg,
                                           input logic [3:0] code, input logic wr, input logic go);
    return {16'h0, phy, rg, code, wr, go};
  endfunction

  logic [4:0]  e_phy, e_reg;
  logic [3:0]  e_code;
  logic        e_wr;
  logic [15:0] e_data;

  task automatic launch(input logic [4:0] phy, input logic [4:0] rg, input logic [3:0] code,
                        input logic wr, input logic [15:0] d, input logic [15:0] resp);
    e_phy = phy; e_reg = rg; e_code = code; e_wr = wr; e_data = d;
    resp_q = resp; mdio_i = 1'b1; base = rise_cnt;
    if (wr) begin
      bus_write(1'b1, {16'hDEAD, d});
      check(data_o == {16'h0, d}, "R9 data readback", data_o, {16'h0, d});
    end
    bus_write(1'b0, cmd_word(phy, rg, code, wr, 1'b1));
    check(cmd_o == cmd_word(phy, rg, code, wr, 1'b1), "R2 busy readback", cmd_o,
          cmd_word(phy, rg, code, wr, 1'b1));
  endtask

  task automatic finish_frame();
    int t = 0;
    logic [63:0] exp, got;
    logic [63:0] oe_got, oe_exp;
    while (cmd_o[0] && t < 6000) begin @(negedge clk); t++; end
    check(!cmd_o[0], "R2 busy clears", cmd_o, 0);
    check(rise_cnt - base == 64, "R4 rising edge count", rise_cnt - base, 64);
    check(rise_cyc[1] - rise_cyc[0] == ratio(e_code), "R3 mdc period",
          rise_cyc[1] - rise_cyc[0], ratio(e_code));
    exp = exp_frame(e_phy, e_reg, e_wr, e_data);
    for (int i = 0; i < 64; i++) begin
      got[63-i]    = cap_bit[i];
      oe_got[63-i] = cap_oe[i];
      oe_exp[63-i] = e_wr ? 1'b1 : (i < 46);
    end
    if (!e_wr) got[17:0] = '0;
    if (e_wr) check(got == exp, "R4 write frame bits", got, exp);
    else      check(got == exp, "R5 read frame header", got, exp);
    check(oe_got == oe_exp, e_wr ? "R4 mdio driven" : "R5 mdio released", oe_got, oe_exp);
    if (e_wr) check(data_o == {16'h0, e_data}, "R9 data kept after write", data_o, e_data);
    else      check(data_o == {16'h0, resp_q}, "R5 read data", data_o, resp_q);
    check(!mdc_o && !mdio_oe_o, "R3 idle after frame", {mdc_o, mdio_oe_o}, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0000_1d5e));
    repeat (3) @(negedge clk);
    check(cmd_o == 0 && data_o == 0, "R1 reset readback", {cmd_o, data_o}, 0);
    check(!mdc_o && !mdio_oe_o, "R1 reset pins", {mdc_o, mdio_oe_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed frames across codes and data extremes
    launch(5'd1, 5'd0, 4'd0, 1'b1, 16'hA5C3, 16'h0);   finish_frame();
    launch(5'd31, 5'd31, 4'd1, 1'b0, 16'h0, 16'hFFFF); finish_frame();
    launch(5'd0, 5'd2, 4'd2, 1'b0, 16'h0, 16'h0000);   finish_frame();
    launch(5'd16, 5'd21, 4'd3, 1'b1, 16'hFFFF, 16'h0); finish_frame();
    launch(5'd9, 5'd4, 4'd9, 1'b0, 16'h0, 16'h8001);   finish_frame();

    // R7: conflicting host writes during a frame
    launch(5'd3, 5'd7, 4'd0, 1'b1, 16'h5A0F, 16'h0);
    repeat (5) @(negedge clk);
    bus_write(1'b0, cmd_word(5'd30, 5'd1, 4'd3, 1'b0, 1'b1));
    bus_write(1'b1, 32'h0000_1234);
    check(cmd_o == cmd_word(5'd3, 5'd7, 4'd0, 1'b1, 1'b1), "R7 cmd ignored while busy",
          cmd_o, cmd_word(5'd3, 5'd7, 4'd0, 1'b1, 1'b1));
    check(data_o == 32'h5A0F, "R7 data ignored while busy", data_o, 32'h5A0F);
    finish_frame();

    // R8: all-zero command still clocks MDC once
    begin
      int r0, o0;
      logic [31:0] d0;
      d0 = data_o; r0 = rise_cnt; o0 = oe_cyc;
      bus_write(1'b0, 32'h0);
      check(cmd_o[0] == 1'b1, "R8 busy during pulse", cmd_o[0], 1);
      repeat (60) @(negedge clk);
      check(rise_cnt - r0 == 1, "R8 single mdc pulse", rise_cnt - r0, 1);
      check(oe_cyc == o0, "R8 mdio released", oe_cyc - o0, 0);
      check(cmd_o[0] == 1'b0 && data_o == d0, "R8 idle and data kept", {cmd_o[0], data_o}, d0);
    end

    // random frames
    for (int n = 0; n < 10; n++) begin
      logic [4:0] p, g;
      logic [3:0] c;
      logic w;
      logic [15:0] d, r;
      p = 5'($urandom); g = 5'($urandom); c = 4'($urandom); w = 1'($urandom);
      d = 16'($urandom); r = 16'($urandom);
      launch(p, g, c, w, d, r);
      finish_frame();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule